// File: doc/BRIEF.md
# SPI Register Command Engine

This block is a serial-peripheral slave that gives a host access to a 128-byte register file. Each transaction is one chip-select frame. The first byte of the frame is an opcode. The opcode selects one of four burst types:

- a continuous write that starts at an address supplied by the host;
- a single read of one addressed register;
- a status read burst that starts at a fixed base;
- an instruction write burst that starts at a fixed base.

During write-type traffic the received bits are mirrored straight back on the output line, so the host can confirm what arrived. During reads the engine shifts out register data instead.

The serial pins are treated as already synchronous to the system clock. SCLK edges are found by comparing each sample with the previous one. The register file sits outside the block, on a plain port: an address, a write strobe, write data, and read data that is registered one clock after the address. The clock-enable input `chan_en` gates all commands.

Faults are reported in a two-bit status byte. A command issued while the channel is disabled, or an unknown opcode, raises the error flag. An out-of-range address raises the fail flag; from then on, writes stop, the pointer stops advancing and read data is forced to zero. Both flags hold until the next frame begins.

Top module: `spi_regcmd_engine`

## Requirements
- R1: Bytes are shifted MSB first. MOSI is taken on the SCLK rising edge and registered MISO data changes on the falling edge. While `spi_cs_n` is high, MISO is 0 and the bit counter and command state return to the opcode phase.
- R2: Opcode 0xCF takes the next byte as a start address, then writes each following byte to the current address and increments the address after every write.
- R3: MISO equals MOSI during the opcode byte, during the address byte of 0xCF and 0x79, and during every data byte of 0xCF and 0xD9.
- R4: Opcode 0x9C shifts out the register at 0x70 in the byte after the opcode, then 0x71, 0x72 and 0x73 in the following bytes. Reading exactly these four bytes leaves the fail flag clear.
- R5: Opcode 0xD9 writes the following bytes to consecutive addresses starting at 0x74, with no address byte.
- R6: Opcode 0x79 takes one address byte and shifts out that register in the next byte. Any further bytes in the frame read as 0x00.
- R7: A known opcode received while `chan_en` is 0 sets the error flag and performs no write. MISO reads 0x00 for the rest of the frame.
- R8: An opcode other than 0xCF, 0x9C, 0xD9 and 0x79 sets the error flag. MISO reads 0x00 for the rest of the frame.
- R9: The fail flag is set and the byte is not written in two cases: a 0xCF data byte aimed above 0x6F, or a 0xD9 data byte aimed above 0x7F. After that, no later byte in the frame is written.
- R10: The fail flag is set and the data byte reads 0x00 in two cases: a 0x9C burst that clocks a fifth data byte, or a 0x79 address at or above 0x80.
- R11: `spi_status` carries the error flag in bit 0 and the fail flag in bit 1, with bits 7..2 zero. The flags stay set after `spi_cs_n` rises and clear on the clock after `spi_cs_n` falls.
- R12: Raising `spi_cs_n` part way through a byte discards the partial byte without a write. The next frame starts again at the opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock, idle low, synchronous to clk |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| chan_en | input | 1 | Register channel enable, sampled at the end of the opcode |
| reg_addr | output | 7 | Register file address |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data, valid one clock after `reg_addr` |
| spi_status | output | 8 | Status byte: bit 0 error, bit 1 fail |

## Verification
The hardest case to reach from the pins is a fault in the middle of a long burst. The fail flag must freeze the pointer and suppress every later write, and only the absence of writes shows this. The bench reaches it in three ways:

- It runs an instruction burst of fourteen data bytes, so the pointer walks through 0x7F and then overflows.
- It starts a continuous write at 0x6E and keeps clocking after 0x6F.
- It clocks a fifth status byte.

In every case the scoreboard queue holds only the writes that are legal. Any extra strobe therefore shows up as an unexpected write.

// File: rtl/spi_regcmd_pkg.sv
package spi_regcmd_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        PH_OPCODE = 3'd0,
        PH_WADDR  = 3'd1,
        PH_WDATA  = 3'd2,
        PH_INSTR  = 3'd3,
        PH_RADDR  = 3'd4,
        PH_RDATA  = 3'd5,
        PH_STAT   = 3'd6,
        PH_MUTE   = 3'd7
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic [BYTE_W-1:0]   ptr;
        logic [BYTE_W-1:0]   tx;
        logic                err;
        logic                fail;
        logic                we;
        logic [BYTE_W-1:0]   wdata;
        logic                bump;
    } eng_s;

endpackage

// File: rtl/spi_regcmd_edges.sv
module spi_regcmd_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sclk,
    input  logic spi_cs_n,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_fall
);
    logic sclk_q, sclk_d;
    logic cs_q, cs_d;

    always_comb begin
        sclk_d = spi_sclk;
        cs_d   = spi_cs_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
        end else begin
            sclk_q <= sclk_d;
            cs_q   <= cs_d;
        end
    end

    assign sclk_rise = spi_sclk & ~sclk_q;
    assign sclk_fall = ~spi_sclk & sclk_q;
    assign cs_fall   = ~spi_cs_n & cs_q;
endmodule

// File: rtl/spi_regcmd_rx.sv
module spi_regcmd_rx #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         spi_cs_n,
    input  logic         sample,
    input  logic         spi_mosi,
    output logic         byte_done,
    output logic [W-1:0] byte_val,
    output logic         at_boundary
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [CW-1:0] cnt_q, cnt_d;
    logic [W-2:0]  sh_q, sh_d;

    always_comb begin
        cnt_d = cnt_q;
        sh_d  = sh_q;
        if (spi_cs_n) begin
            cnt_d = '0;
            sh_d  = '0;
        end else if (sample) begin
            sh_d  = {sh_q[W-3:0], spi_mosi};
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sh_q  <= '0;
        end else begin
            cnt_q <= cnt_d;
            sh_q  <= sh_d;
        end
    end

    assign byte_done   = !spi_cs_n && sample && (cnt_q == LAST);
    assign byte_val    = {sh_q, spi_mosi};
    assign at_boundary = (cnt_q == '0);
endmodule

// File: rtl/spi_regcmd_engine.sv
module spi_regcmd_engine
    import spi_regcmd_pkg::*;
#(
    parameter int          REG_AW     = 7,
    parameter logic [7:0]  OPC_WRITE  = 8'hCF,
    parameter logic [7:0]  OPC_STAT   = 8'h9C,
    parameter logic [7:0]  OPC_INSTR  = 8'hD9,
    parameter logic [7:0]  OPC_READ   = 8'h79,
    parameter logic [7:0]  WR_LAST    = 8'h6F,
    parameter logic [7:0]  STAT_FIRST = 8'h70,
    parameter logic [7:0]  STAT_LAST  = 8'h73,
    parameter logic [7:0]  INST_FIRST = 8'h74,
    parameter logic [7:0]  INST_LAST  = 8'h7F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic              chan_en,
    output logic [REG_AW-1:0] reg_addr,
    output logic              reg_we,
    output logic [BYTE_W-1:0] reg_wdata,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic [BYTE_W-1:0] spi_status
);
    localparam int          SPAN   = 1 << REG_AW;
    localparam logic [7:0]  RD_TOP = 8'(SPAN - 1);

    logic              sclk_rise, sclk_fall, cs_fall;
    logic              byte_done, at_boundary;
    logic [BYTE_W-1:0] byte_val;
    logic              echo_ph, read_ph;
    logic [BYTE_W-1:0] load_val;
    eng_s              q, n;

    spi_regcmd_edges u_edges (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_sclk  (spi_sclk),
        .spi_cs_n  (spi_cs_n),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_fall   (cs_fall)
    );

    spi_regcmd_rx #(.W(BYTE_W)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_cs_n    (spi_cs_n),
        .sample      (sclk_rise),
        .spi_mosi    (spi_mosi),
        .byte_done   (byte_done),
        .byte_val    (byte_val),
        .at_boundary (at_boundary)
    );

    always_comb begin
        echo_ph = (q.phase == PH_OPCODE) || (q.phase == PH_WADDR) ||
                  (q.phase == PH_WDATA)  || (q.phase == PH_INSTR) ||
                  (q.phase == PH_RADDR);
        read_ph = (q.phase == PH_RDATA) || (q.phase == PH_STAT);
        if (read_ph && !q.fail && !((q.phase == PH_STAT) && (q.ptr > STAT_LAST)))
            load_val = reg_rdata;
        else
            load_val = '0;
    end

    always_comb begin
        n    = q;
        n.we = 1'b0;
        if (q.bump) begin
            n.ptr  = q.ptr + 1'b1;
            n.bump = 1'b0;
        end
        if (cs_fall) begin
            n.err  = 1'b0;
            n.fail = 1'b0;
        end
        if (spi_cs_n) begin
            n.phase = PH_OPCODE;
            n.tx    = '0;
        end else begin
            if (sclk_fall)
                n.tx = at_boundary ? load_val : {q.tx[BYTE_W-2:0], 1'b0};
            if (sclk_rise && at_boundary && (q.phase == PH_STAT) && (q.ptr > STAT_LAST))
                n.fail = 1'b1;
            if (byte_done) begin
                unique case (q.phase)
                    PH_OPCODE: begin
                        if ((byte_val == OPC_WRITE) || (byte_val == OPC_STAT) ||
                            (byte_val == OPC_INSTR) || (byte_val == OPC_READ)) begin
                            if (!chan_en) begin
                                n.err   = 1'b1;
                                n.phase = PH_MUTE;
                            end else if (byte_val == OPC_WRITE) begin
                                n.phase = PH_WADDR;
                            end else if (byte_val == OPC_STAT) begin
                                n.phase = PH_STAT;
                                n.ptr   = STAT_FIRST;
                            end else if (byte_val == OPC_INSTR) begin
                                n.phase = PH_INSTR;
                                n.ptr   = INST_FIRST;
                            end else begin
                                n.phase = PH_RADDR;
                            end
                        end else begin
                            n.err   = 1'b1;
                            n.phase = PH_MUTE;
                        end
                    end
                    PH_WADDR: begin
                        n.ptr   = byte_val;
                        n.phase = PH_WDATA;
                        if (byte_val > WR_LAST) n.fail = 1'b1;
                    end
                    PH_WDATA: begin
                        if (!q.fail && (q.ptr <= WR_LAST)) begin
                            n.we    = 1'b1;
                            n.wdata = byte_val;
                            n.bump  = 1'b1;
                        end else begin
                            n.fail = 1'b1;
                        end
                    end
                    PH_INSTR: begin
                        if (!q.fail && (q.ptr >= INST_FIRST) && (q.ptr <= INST_LAST)) begin
                            n.we    = 1'b1;
                            n.wdata = byte_val;
                            n.bump  = 1'b1;
                        end else begin
                            n.fail = 1'b1;
                        end
                    end
                    PH_RADDR: begin
                        n.ptr   = byte_val;
                        n.phase = PH_RDATA;
                        if (byte_val > RD_TOP) n.fail = 1'b1;
                    end
                    PH_RDATA: n.phase = PH_MUTE;
                    PH_STAT: begin
                        if (!q.fail && (q.ptr <= STAT_LAST)) n.ptr = q.ptr + 1'b1;
                    end
                    default: n.phase = PH_MUTE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    assign spi_miso   = !spi_cs_n && (echo_ph ? spi_mosi : q.tx[BYTE_W-1]);
    assign reg_addr   = q.ptr[REG_AW-1:0];
    assign reg_we     = q.we;
    assign reg_wdata  = q.wdata;
    assign spi_status = {{(BYTE_W-2){1'b0}}, q.fail, q.err};
endmodule

// File: rtl/spi_regcmd_chk.sv
module spi_regcmd_chk #(
    parameter int         REG_AW     = 7,
    parameter logic [7:0] WR_LAST    = 8'h6F,
    parameter logic [7:0] INST_FIRST = 8'h74,
    parameter logic [7:0] INST_LAST  = 8'h7F
) (
    input logic              clk,
    input logic              rst_n,
    input logic              spi_cs_n,
    input logic              reg_we,
    input logic [REG_AW-1:0] reg_addr,
    input logic [7:0]        spi_status
);
    logic [7:0] wa;
    assign wa = 8'(reg_addr);

    AST_WE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we); // R2

    AST_WE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> ((wa <= WR_LAST) || ((wa >= INST_FIRST) && (wa <= INST_LAST)))); // R9

    AST_WE_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (spi_status[1:0] == 2'b00)); // R7

    AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |=> (spi_status[1:0] == 2'b00)); // R11

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_status[0] && !$fell(spi_cs_n)) |=> spi_status[0]); // R11

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_status[1] && !$fell(spi_cs_n)) |=> spi_status[1]); // R11

    AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_status[0]) |-> (spi_status[7:2] == 6'd0)); // R11
endmodule

bind spi_regcmd_engine spi_regcmd_chk #(
    .REG_AW     (REG_AW),
    .WR_LAST    (WR_LAST),
    .INST_FIRST (INST_FIRST),
    .INST_LAST  (INST_LAST)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .spi_cs_n   (spi_cs_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .spi_status (spi_status)
);

// File: tb/spi_regcmd_engine_bench.sv
module spi_regcmd_engine_bench;
    localparam int H = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sclk = 1'b0;
    logic       spi_cs_n = 1'b1;
    logic       spi_mosi = 1'b0;
    logic       spi_miso;
    logic       chan_en = 1'b1;
    logic [6:0] reg_addr;
    logic       reg_we;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata = 8'h00;
    logic [7:0] spi_status;

    logic [7:0]  mem [0:127];
    logic [15:0] exp_wr [$];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    spi_regcmd_engine u_spi_regcmd_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .spi_sclk   (spi_sclk),
        .spi_cs_n   (spi_cs_n),
        .spi_mosi   (spi_mosi),
        .spi_miso   (spi_miso),
        .chan_en    (chan_en),
        .reg_addr   (reg_addr),
        .reg_we     (reg_we),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .spi_status (spi_status)
    );

    always @(posedge clk) reg_rdata <= mem[reg_addr];

    // scoreboard monitor for register writes (R2, R5, R9)
    always @(negedge clk) begin
        if (rst_n && reg_we) begin
            checks++;
            if (exp_wr.size() == 0) begin
                errors++;
                $display("FAIL R9 unexpected write got %h:%h exp none", reg_addr, reg_wdata);
            end else begin
                logic [15:0] e;
                e = exp_wr.pop_front();
                if ({1'b0, reg_addr, reg_wdata} !== e) begin
                    errors++;
                    $display("FAIL R2/R5 write got %h:%h exp %h:%h",
                             reg_addr, reg_wdata, e[15:8], e[7:0]);
                end
            end
            mem[reg_addr] = reg_wdata;
        end
    end

    task automatic chk(input string rq, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", rq, got, exp);
        end
    endtask

    task automatic cs_lo();
        @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (H) @(negedge clk);
    endtask

    task automatic cs_hi();
        repeat (H) @(negedge clk);
        spi_cs_n = 1'b1;
        spi_mosi = 1'b0;
        repeat (H) @(negedge clk);
    endtask

    task automatic xbits(input logic [7:0] tx, input int nb, output logic [7:0] got);
        got = 8'h00;
        for (int i = 7; i > 7 - nb; i--) begin
            spi_mosi = tx[i];
            repeat (H) @(negedge clk);
            got[i] = spi_miso;
            spi_sclk = 1'b1;
            repeat (H) @(negedge clk);
            spi_sclk = 1'b0;
        end
    endtask

    task automatic xbyte(input logic [7:0] tx, input logic [7:0] exp, input string rq);
        logic [7:0] got;
        xbits(tx, 8, got);
        chk(rq, {24'd0, got}, {24'd0, exp});
    endtask

    task automatic push_wr(input logic [7:0] a, input logic [7:0] d);
        exp_wr.push_back({a, d});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = 8'((i * 7 + 3) ^ 8'h5A);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        spi_mosi = 1'b1;
        repeat (2) @(negedge clk);
        // R1: reset state and idle MISO
        chk("R1 miso idle", {31'd0, spi_miso}, 32'd0);
        chk("R1 status reset", {24'd0, spi_status}, 32'd0);
        chk("R1 we reset", {31'd0, reg_we}, 32'd0);
        spi_mosi = 1'b0;

        // R2 R3: continuous write with echo
        cs_lo();
        xbyte(8'hCF, 8'hCF, "R3 opcode echo");
        xbyte(8'h10, 8'h10, "R3 addr echo");
        push_wr(8'h10, 8'hA1); xbyte(8'hA1, 8'hA1, "R3 data echo");
        push_wr(8'h11, 8'hB2); xbyte(8'hB2, 8'hB2, "R3 data echo");
        push_wr(8'h12, 8'hC3); xbyte(8'hC3, 8'hC3, "R3 data echo");
        cs_hi();
        chk("R2 status clean", {24'd0, spi_status}, 32'd0);

        // R6: single read with trailing zero byte
        cs_lo();
        xbyte(8'h79, 8'h79, "R3 read opcode echo");
        xbyte(8'h11, 8'h11, "R3 read addr echo");
        xbyte(8'hFF, 8'hB2, "R6 read data");
        xbyte(8'hFF, 8'h00, "R6 trailing zero");
        cs_hi();

        // R4 R10: status burst past the end
        cs_lo();
        xbyte(8'h9C, 8'h9C, "R3 stat opcode echo");
        for (int a = 8'h70; a <= 8'h73; a++) xbyte(8'h00, mem[a], "R4 status data");
        xbyte(8'h00, 8'h00, "R10 status overrun zero");
        cs_hi();
        chk("R10 fail after overrun", {24'd0, spi_status}, 32'h2);

        // R11 clear on new frame, R5 instruction write
        cs_lo();
        chk("R11 clear on frame start", {24'd0, spi_status}, 32'd0);
        xbyte(8'hD9, 8'hD9, "R3 instr opcode echo");
        push_wr(8'h74, 8'h5A); xbyte(8'h5A, 8'h5A, "R5 instr echo");
        push_wr(8'h75, 8'h6B); xbyte(8'h6B, 8'h6B, "R5 instr echo");
        cs_hi();
        chk("R5 status clean", {24'd0, spi_status}, 32'd0);

        // R4: exactly four status bytes leave fail clear
        cs_lo();
        xbyte(8'h9C, 8'h9C, "R4 opcode echo");
        for (int a = 8'h70; a <= 8'h73; a++) xbyte(8'h00, mem[a], "R4 status exact");
        cs_hi();
        chk("R4 no fail", {24'd0, spi_status}, 32'd0);

        // R9: instruction burst overflows past 0x7F
        cs_lo();
        xbyte(8'hD9, 8'hD9, "R3 opcode echo");
        for (int k = 0; k < 14; k++) begin
            if (k < 12) push_wr(8'(8'h74 + k), 8'(8'h20 + k));
            xbyte(8'(8'h20 + k), 8'(8'h20 + k), "R3 instr burst echo");
        end
        cs_hi();
        chk("R9 instr overflow fail", {24'd0, spi_status}, 32'h2);

        // R9: continuous write runs past 0x6F
        cs_lo();
        xbyte(8'hCF, 8'hCF, "R3 opcode echo");
        xbyte(8'h6E, 8'h6E, "R3 addr echo");
        push_wr(8'h6E, 8'h91); xbyte(8'h91, 8'h91, "R9 echo");
        push_wr(8'h6F, 8'h92); xbyte(8'h92, 8'h92, "R9 echo");
        xbyte(8'h93, 8'h93, "R9 echo after fail");
        xbyte(8'h94, 8'h94, "R9 echo after fail");
        cs_hi();
        chk("R9 write overflow fail", {24'd0, spi_status}, 32'h2);

        // R9: bad start address
        cs_lo();
        xbyte(8'hCF, 8'hCF, "R3 opcode echo");
        xbyte(8'h75, 8'h75, "R3 addr echo");
        xbyte(8'h33, 8'h33, "R9 echo");
        cs_hi();
        chk("R9 bad start fail", {24'd0, spi_status}, 32'h2);

        // R7: channel disabled
        chan_en = 1'b0;
        cs_lo();
        xbyte(8'hCF, 8'hCF, "R7 opcode echo");
        xbyte(8'h10, 8'h00, "R7 muted");
        xbyte(8'h55, 8'h00, "R7 muted");
        cs_hi();
        chk("R7 error flag", {24'd0, spi_status}, 32'h1);
        chan_en = 1'b1;

        // R8: unknown opcode
        cs_lo();
        xbyte(8'h42, 8'h42, "R8 opcode echo");
        xbyte(8'hFF, 8'h00, "R8 muted");
        cs_hi();
        chk("R8 error flag", {24'd0, spi_status}, 32'h1);
        repeat (10) @(negedge clk);
        chk("R11 retained while idle", {24'd0, spi_status}, 32'h1);

        // R10: read address out of range
        cs_lo();
        chk("R11 cleared", {24'd0, spi_status}, 32'd0);
        xbyte(8'h79, 8'h79, "R3 opcode echo");
        xbyte(8'h90, 8'h90, "R3 addr echo");
        xbyte(8'hFF, 8'h00, "R10 invalid read zero");
        cs_hi();
        chk("R10 read fail", {24'd0, spi_status}, 32'h2);

        // R12: abort mid-byte, then verify nothing changed
        cs_lo();
        xbyte(8'hCF, 8'hCF, "R3 opcode echo");
        xbyte(8'h20, 8'h20, "R3 addr echo");
        begin
            logic [7:0] junk;
            xbits(8'hFF, 4, junk);
        end
        cs_hi();
        chk("R12 no fault on abort", {24'd0, spi_status}, 32'd0);
        cs_lo();
        xbyte(8'h79, 8'h79, "R12 new frame opcode");
        xbyte(8'h20, 8'h20, "R12 addr echo");
        xbyte(8'h00, mem[8'h20], "R12 register unchanged");
        cs_hi();

        // R1: MISO low again after frame with MOSI high
        spi_mosi = 1'b1;
        repeat (H) @(negedge clk);
        chk("R1 miso idle after frame", {31'd0, spi_miso}, 32'd0);
        spi_mosi = 1'b0;

        chk("R2 all expected writes seen", exp_wr.size(), 32'd0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule